// File: doc/BRIEF.md
# Flash Partition Access Guard

This block sits between a flash request arbiter and the flash bus. It checks every granted request against per-partition access rights held for two requesting domains, primary and secondary. The 4 MB flash space is split into sixteen partitions of 256 KB. Each partition carries three rights bits: an ownership bit, an owner read-only bit and a non-owner read bit. The block decides for each request whether it passes to the flash bus or is blocked.

A blocked request either returns an error pulse or is dropped silently, depending on a control input. While partition configuration mode is active, the secondary domain is shut out completely. In that mode the primary domain may start a mass erase when a separate enable input allows it.

The block keeps the first violation it sees. It raises a sticky flag and holds that request's address until the next reset. The rights vectors and mode inputs are treated as static configuration.

Top module: `flash_part_guard`

## Requirements
- R1: After reset, `fwdValid`, `errResp` and `violFlag` are 0 and `violAddr` is all zeros.
- R2: The partition index is taken from address bits [21:18] only. An ownership bit of 1 gives the partition to the primary domain (`reqDomain`=1); a 0 gives it to the secondary domain (`reqDomain`=0).
- R3: With its read-only bit at 0, the owner of a partition may read (`reqKind`=0), write (`reqKind`=1) and erase (`reqKind`=2) it, and each such request is forwarded.
- R4: With its read-only bit at 1, the owner's reads are forwarded and the owner's writes and erases are blocked.
- R5: A non-owner read is forwarded only when the partition's open-read bit is 1. Non-owner writes and erases are always blocked.
- R6: While `cfgMode` is 1, every request from the secondary domain is blocked and receives an error pulse, whatever `errRespEn` holds.
- R7: A mass erase (`reqKind`=3) from the primary domain while `cfgMode` is 1 is forwarded when `massEraseEn` is 1 and blocked when it is 0, regardless of the partition vectors.
- R8: A mass erase outside configuration mode is forwarded only when the requesting domain owns all sixteen partitions and no partition is read-only. The address is ignored.
- R9: A blocked request outside R6 raises `errResp` when `errRespEn` is 1. When `errRespEn` is 0 it is dropped with neither output raised. `fwdValid` and `errResp` are never high together.
- R10: The first blocked request after reset sets `violFlag` and loads its address into `violAddr`. Both then hold until reset, ignoring later violations.
- R11: `fwdValid` and `errResp` pulse for one cycle, in the cycle after the request is presented. Cycles without a request produce neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A granted request is present |
| reqAddr | input | 22 | Request byte address |
| reqKind | input | 2 | 0 read, 1 write, 2 erase, 3 mass erase |
| reqDomain | input | 1 | 1 primary, 0 secondary |
| partOwner | input | 16 | Ownership bit per partition, 1 = primary |
| partOpenRead | input | 16 | Non-owner read permitted per partition |
| partReadOnly | input | 16 | Owner limited to reads per partition |
| cfgMode | input | 1 | Partition configuration mode active |
| massEraseEn | input | 1 | Allows primary mass erase in configuration mode |
| errRespEn | input | 1 | 1 = blocked requests get an error, 0 = dropped silently |
| fwdValid | output | 1 | Request forwarded to the flash bus |
| errResp | output | 1 | Error response for a blocked request |
| violFlag | output | 1 | Sticky violation flag |
| violAddr | output | 22 | Address of the first blocked request |

## Verification
Reads, writes and erases from both domains are swept over partitions that are owned and open, owned and read-only, foreign and closed, and foreign but open-read. This separates the ownership, read-only and open-read paths from one another. Addresses with their low 18 bits all set show whether the partition index is taken from the right field. The same blocked requests are repeated with the error control off, which separates an error reply from a silent drop. Configuration-mode runs pair secondary requests with primary mass erases, with the enable both on and off. Whole-array mass erases use ownership vectors that are complete, incomplete and complete-but-read-only. A mid-run reset followed by a new violation shows that the first-violation capture starts afresh.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_ERASE = 2'd2,
    KIND_MASS  = 2'd3
  } reqKind_e;

  // strobes from the decision logic to the register stage
  typedef struct packed {
    logic fwd;
    logic err;
    logic capture;
  } guardStrobe_t;
endpackage

// File: rtl/fpg_ctrl.sv
module fpg_ctrl
  import fpg_pkg::*;
#(
  parameter int NPART  = 16,
  parameter int PART_W = $clog2(NPART)
) (
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqDomain,
  input  logic [PART_W-1:0] partIdx,
  input  logic [NPART-1:0]  partOwner,
  input  logic [NPART-1:0]  partOpenRead,
  input  logic [NPART-1:0]  partReadOnly,
  input  logic              cfgMode,
  input  logic              massEraseEn,
  input  logic              errRespEn,
  output guardStrobe_t      strobe
);
  reqKind_e         kind;
  logic             isOwner;
  logic [NPART-1:0] ownedMask;
  logic             wholeArrayMine;
  logic             lockedOut;
  logic             allowed;
  logic             permit;
  logic             deny;

  always_comb begin
    kind           = reqKind_e'(reqKind);
    isOwner        = (partOwner[partIdx] == reqDomain);
    ownedMask      = reqDomain ? partOwner : ~partOwner;
    wholeArrayMine = (&ownedMask) && !(|partReadOnly);
    lockedOut      = cfgMode && !reqDomain;

    unique case (kind)
      KIND_READ:              allowed = isOwner || partOpenRead[partIdx];
      KIND_WRITE, KIND_ERASE: allowed = isOwner && !partReadOnly[partIdx];
      KIND_MASS:              allowed = cfgMode ? massEraseEn : wholeArrayMine;
      default:                allowed = 1'b0;
    endcase

    permit = reqValid && !lockedOut && allowed;
    deny   = reqValid && !permit;

    strobe.fwd     = permit;
    strobe.err     = deny && (errRespEn || lockedOut);
    strobe.capture = deny;
  end
endmodule

// File: rtl/fpg_datapath.sv
module fpg_datapath
  import fpg_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  guardStrobe_t      strobe,
  output logic [PART_W-1:0] partIdx,
  output logic              fwdValid,
  output logic              errResp,
  output logic              violFlag,
  output logic [ADDR_W-1:0] violAddr
);
  assign partIdx = reqAddr[ADDR_W-1 -: PART_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      errResp  <= 1'b0;
      violFlag <= 1'b0;
      violAddr <= '0;
    end else begin
      fwdValid <= strobe.fwd;
      errResp  <= strobe.err;
      if (strobe.capture && !violFlag) begin
        violFlag <= 1'b1;
        violAddr <= reqAddr;
      end
    end
  end
endmodule

// File: rtl/flash_part_guard.sv
module flash_part_guard
  import fpg_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int NPART  = 16,
  localparam int PART_W = $clog2(NPART)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqDomain,
  input  logic [NPART-1:0]  partOwner,
  input  logic [NPART-1:0]  partOpenRead,
  input  logic [NPART-1:0]  partReadOnly,
  input  logic              cfgMode,
  input  logic              massEraseEn,
  input  logic              errRespEn,
  output logic              fwdValid,
  output logic              errResp,
  output logic              violFlag,
  output logic [ADDR_W-1:0] violAddr
);
  guardStrobe_t      strobe;
  logic [PART_W-1:0] partIdx;

  fpg_ctrl #(.NPART(NPART), .PART_W(PART_W)) uCtrl (
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .reqDomain   (reqDomain),
    .partIdx     (partIdx),
    .partOwner   (partOwner),
    .partOpenRead(partOpenRead),
    .partReadOnly(partReadOnly),
    .cfgMode     (cfgMode),
    .massEraseEn (massEraseEn),
    .errRespEn   (errRespEn),
    .strobe      (strobe)
  );

  fpg_datapath #(.ADDR_W(ADDR_W), .PART_W(PART_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .reqAddr (reqAddr),
    .strobe  (strobe),
    .partIdx (partIdx),
    .fwdValid(fwdValid),
    .errResp (errResp),
    .violFlag(violFlag),
    .violAddr(violAddr)
  );
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int ADDR_W = 22,
  parameter int NPART  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqKind,
  input logic              reqDomain,
  input logic [NPART-1:0]  partOwner,
  input logic [NPART-1:0]  partOpenRead,
  input logic [NPART-1:0]  partReadOnly,
  input logic              cfgMode,
  input logic              massEraseEn,
  input logic              errRespEn,
  input logic              fwdValid,
  input logic              errResp,
  input logic              violFlag,
  input logic [ADDR_W-1:0] violAddr
);
  localparam int PART_W = $clog2(NPART);
  logic [PART_W-1:0] chkPart;
  assign chkPart = reqAddr[ADDR_W-1 -: PART_W];

  assert_fwd_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && errResp));

  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |=> (violFlag && $stable(violAddr)));

  assert_secondary_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDomain && cfgMode) |=> (errResp && !fwdValid));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!fwdValid && !errResp));

  assert_foreign_modify_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqKind == 2'd1 || reqKind == 2'd2) && (partOwner[chkPart] != reqDomain))
      |=> !fwdValid);

  assert_cfg_mass_erase_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd3 && reqDomain && cfgMode && massEraseEn) |=> fwdValid);
endmodule

bind flash_part_guard fpg_checker #(.ADDR_W(ADDR_W), .NPART(NPART)) uChk (.*);

// File: tb/sim_flash_part_guard.sv
`timescale 1ns/1ps
module sim_flash_part_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqDomain = 1'b0;
  logic [15:0] partOwner = '0;
  logic [15:0] partOpenRead = '0;
  logic [15:0] partReadOnly = '0;
  logic        cfgMode = 1'b0;
  logic        massEraseEn = 1'b0;
  logic        errRespEn = 1'b1;
  logic        fwdValid, errResp, violFlag;
  logic [21:0] violAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          expFwd, expErr, expFlag;
  logic [21:0] expAddr;
  string       ruleTag, errTag, tagOverride;

  always #4 clk = ~clk;

  flash_part_guard u0 (.*);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (addr=%0h kind=%0d dom=%0d)",
               tag, what, act, exp, reqAddr, reqKind, reqDomain);
    end
  endtask

  // behavioural reference: decision for the inputs currently applied
  task automatic model();
    int  part;
    bit  own, allowed, locked, mine;
    part    = int'(reqAddr) / (1 << 18);
    own     = (partOwner[part] == reqDomain);
    locked  = cfgMode && !reqDomain;
    allowed = 0;
    if (!reqValid) ruleTag = "R11";
    else if (locked) ruleTag = "R6";
    else if (reqKind == 3) begin
      if (cfgMode) begin
        ruleTag = "R7"; allowed = massEraseEn;
      end else begin
        mine = 1;
        for (int i = 0; i < 16; i++)
          if (partOwner[i] != reqDomain || partReadOnly[i]) mine = 0;
        ruleTag = "R8"; allowed = mine;
      end
    end else if (reqKind == 0) begin
      allowed = own || partOpenRead[part];
      ruleTag = own ? "R3" : "R5";
    end else begin
      if (!own) begin ruleTag = "R5"; allowed = 0; end
      else if (partReadOnly[part]) begin ruleTag = "R4"; allowed = 0; end
      else begin ruleTag = "R3"; allowed = 1; end
    end
    if (tagOverride != "") ruleTag = tagOverride;
    allowed = reqValid && !locked && allowed;
    expFwd  = allowed;
    expErr  = reqValid && !allowed && (errRespEn || locked);
    errTag  = locked ? "R6" : "R9";
    if (reqValid && !allowed && !expFlag) begin
      expFlag = 1;
      expAddr = reqAddr;
    end
  endtask

  task automatic cycle(input bit v, input bit dom, input int kind, input logic [21:0] addr);
    reqValid  = v;
    reqDomain = dom;
    reqKind   = 2'(kind);
    reqAddr   = addr;
    model();
    @(posedge clk);
    #1;
    check(ruleTag, "fwdValid", 32'(fwdValid), 32'(expFwd));
    check(errTag, "errResp", 32'(errResp), 32'(expErr));
    check("R10", "violFlag", 32'(violFlag), 32'(expFlag));
    check("R10", "violAddr", 32'(violAddr), 32'(expAddr));
    if (fwdValid && errResp) check("R9", "exclusive", 32'd1, 32'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "fwdValid", 32'(fwdValid), 32'd0);
    check("R1", "errResp", 32'(errResp), 32'd0);
    check("R1", "violFlag", 32'(violFlag), 32'd0);
    check("R1", "violAddr", 32'(violAddr), 32'd0);
    expFwd = 0; expErr = 0; expFlag = 0; expAddr = '0;
    rstN = 1'b1;
  endtask

  initial begin
    tagOverride = "";
    // partitions 0,1 secondary; partition 1 open-read; partition 3 read-only
    partOwner = 16'hFFFC; partOpenRead = 16'h0002; partReadOnly = 16'h0008;
    doReset();
    cycle(0, 0, 0, '0);                   // R11 idle
    foreach (partOwner[d]) begin end
    for (int dom = 0; dom < 2; dom++)
      for (int kind = 0; kind < 3; kind++)
        for (int p = 0; p < 6; p++) begin
          cycle(1, dom[0], kind, 22'((p << 18) | (p * 64 + kind * 4)));
          cycle(0, 0, 0, '0);
        end
    // R2: low address bits all ones must not move the partition
    tagOverride = "R2";
    for (int p = 0; p < 16; p++) cycle(1, 1, 1, 22'((p << 18) | 18'h3FFFF));
    tagOverride = "";
    // R9: silent drop of blocked requests
    errRespEn = 1'b0;
    cycle(1, 0, 1, 22'h0C_0000);
    cycle(1, 1, 2, 22'h00_0100);
    cycle(1, 1, 0, 22'h00_0200);
    errRespEn = 1'b1;
    // R6 / R7: configuration mode
    cfgMode = 1'b1;
    errRespEn = 1'b0;
    cycle(1, 0, 0, 22'h00_0040);
    cycle(1, 0, 3, 22'h00_0000);
    cycle(1, 1, 0, 22'h08_0000);
    massEraseEn = 1'b1;
    cycle(1, 1, 3, 22'h00_0000);
    massEraseEn = 1'b0;
    cycle(1, 1, 3, 22'h00_0000);
    errRespEn = 1'b1;
    cycle(1, 1, 3, 22'h00_0000);
    cfgMode = 1'b0;
    // R8: whole-array mass erase outside configuration mode
    massEraseEn = 1'b1;
    cycle(1, 1, 3, 22'h12_3456);
    partOwner = 16'hFFFF; partReadOnly = 16'h0000;
    cycle(1, 1, 3, 22'h12_3456);
    cycle(1, 0, 3, 22'h12_3456);
    partReadOnly = 16'h0008;
    cycle(1, 1, 3, 22'h00_0000);
    partOwner = 16'h0000; partReadOnly = 16'h0000;
    cycle(1, 0, 3, 22'h00_0000);
    cycle(0, 0, 0, '0);
    // R1 / R10: reset clears capture, next violation is taken afresh
    doReset();
    cycle(0, 0, 0, '0);
    cycle(1, 1, 1, 22'h2A_BCD4);
    cycle(1, 1, 2, 22'h3F_0000);
    cycle(0, 0, 0, '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule